// File: doc/BRIEF.md
# Host Attachment Lookup Table

This block keeps a small associative table of where end hosts connect to a switched network. Each stored entry ties a 48-bit host MAC address to the 64-bit identifier of the switch that host is attached to and the 16-bit port number on that switch. Control software writes an entry through the learn port whenever it notices a new host or network. If that MAC is already stored, the existing entry is updated in place.

Route computation needs to know where both endpoints of a new flow sit. The query port therefore takes a source MAC and a destination MAC in the same request. Both keys are compared against every stored entry at once, so the answer takes the same time however full the table is. The registered result gives a hit flag, a switch identifier and a port for each endpoint, and a one-cycle valid pulse marks it. A full flag tells software that every slot is in use.

Top module: `attach_point_lookup`

## Requirements
- R1: A learn request carrying a MAC that is not yet stored, made while the table is not full, stores that MAC with its switch identifier and port in a free slot. A later query for that MAC returns the stored switch identifier and port.
- R2: One query resolves the source key and the destination key independently and in the same cycle. Swapping the two keys swaps the two result halves, and the same MAC may be given for both keys.
- R3: Each endpoint has its own hit flag, where 1 means found. For an endpoint that misses, the switch identifier and port outputs are zero.
- R4: `res_valid` goes high for exactly one cycle, in the cycle after a cycle in which `query_valid` was high. The result fields keep their values until the next query.
- R5: A learn request for a MAC that is already stored overwrites that entry's switch identifier and port. It does not use up another slot.
- R6: `table_full` is 1 exactly when every slot holds an entry. It stays at 1 until reset.
- R7: A learn request for a new MAC while the table is full is dropped. A learn request for a MAC that is already stored is still applied while the table is full.
- R8: A query made in the same cycle as a learn request sees the table as it was before that learn.
- R9: Reset empties the table and clears `table_full`, `res_valid`, both hit flags and all result fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| learn_valid | input | 1 | Learn request strobe |
| learn_mac | input | 48 | MAC address of the host being learned |
| learn_dpid | input | 64 | Identifier of the switch the host is attached to |
| learn_port | input | 16 | Port on that switch |
| query_valid | input | 1 | Lookup request strobe |
| query_src_mac | input | 48 | Source MAC key |
| query_dst_mac | input | 48 | Destination MAC key |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| src_hit | output | 1 | Source key found |
| src_dpid | output | 64 | Switch identifier for the source |
| src_port | output | 16 | Switch port for the source |
| dst_hit | output | 1 | Destination key found |
| dst_dpid | output | 64 | Switch identifier for the destination |
| dst_port | output | 16 | Switch port for the destination |
| table_full | output | 1 | Every slot holds an entry |

## Verification
The bench builds the table with `ENTRIES = 4`. With that size, four distinct learns fill the table, so the full flag, a dropped learn and an overwrite while full are all reached within a short vector list. The default size of 32 is only elaborated. It uses the same per-slot logic, and its free-slot search and match reduction are just wider.

// File: rtl/attach_pkg.sv
package attach_pkg;
    localparam int MAC_W  = 48;
    localparam int DPID_W = 64;
    localparam int PORT_W = 16;

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic [DPID_W-1:0] dpid;
        logic [PORT_W-1:0] port;
    } attach_t;

    typedef struct packed {
        logic    hit;
        attach_t loc;
    } lookup_t;
endpackage

// File: rtl/attach_match.sv
module attach_match
    import attach_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  mac_t                key,
    input  mac_t                mac_tab [ENTRIES],
    input  attach_t             loc_tab [ENTRIES],
    input  logic [ENTRIES-1:0]  live,
    output lookup_t             res,
    output logic [IDX_W-1:0]    idx
);
    logic [ENTRIES-1:0] hit_v;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_v[g] = live[g] && (mac_tab[g] == key);
        end
    endgenerate

    // Entries are kept unique by the table, so an AND-OR reduction acts as the mux.
    always_comb begin
        attach_t acc;
        acc = '0;
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            acc = acc | ({$bits(attach_t){hit_v[i]}} & loc_tab[i]);
            if (hit_v[i]) idx = IDX_W'(i);
        end
        res.hit = |hit_v;
        res.loc = acc;
    end
endmodule

// File: rtl/attach_table.sv
module attach_table
    import attach_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               learn_en,
    input  mac_t               learn_mac,
    input  attach_t            learn_loc,
    input  logic               learn_hit,
    input  logic [IDX_W-1:0]   learn_idx,
    output mac_t               mac_tab [ENTRIES],
    output attach_t            loc_tab [ENTRIES],
    output logic [ENTRIES-1:0] live,
    output logic               full
);
    logic [IDX_W-1:0] free_idx;
    logic             do_alloc;
    logic             do_write;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) free_idx = IDX_W'(i);
        end
    end

    assign full     = &live;
    assign do_alloc = learn_en && !learn_hit && !full;
    assign do_write = learn_en && (learn_hit || !full);
    assign wr_idx   = learn_hit ? learn_idx : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (do_alloc) begin
            live[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            mac_tab[wr_idx] <= learn_mac;
            loc_tab[wr_idx] <= learn_loc;
        end
    end

    assert_alloc_one_R1: assert property (@(posedge clk) disable iff (rst)
        (learn_en && !learn_hit && !full) |=> ($countones(live) == $past($countones(live)) + 1));

    assert_overwrite_keeps_slots_R5: assert property (@(posedge clk) disable iff (rst)
        (learn_en && learn_hit) |=> $stable(live));

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        full |=> full);
endmodule

// File: rtl/attach_point_lookup.sv
module attach_point_lookup
    import attach_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              learn_valid,
    input  logic [MAC_W-1:0]  learn_mac,
    input  logic [DPID_W-1:0] learn_dpid,
    input  logic [PORT_W-1:0] learn_port,
    input  logic              query_valid,
    input  logic [MAC_W-1:0]  query_src_mac,
    input  logic [MAC_W-1:0]  query_dst_mac,
    output logic              res_valid,
    output logic              src_hit,
    output logic [DPID_W-1:0] src_dpid,
    output logic [PORT_W-1:0] src_port,
    output logic              dst_hit,
    output logic [DPID_W-1:0] dst_dpid,
    output logic [PORT_W-1:0] dst_port,
    output logic              table_full
);
    mac_t               mac_tab [ENTRIES];
    attach_t            loc_tab [ENTRIES];
    logic [ENTRIES-1:0] live;
    lookup_t            learn_res;
    logic [IDX_W-1:0]   learn_idx;
    mac_t               q_key   [2];
    lookup_t            q_res   [2];
    lookup_t            held    [2];

    assign q_key[0] = query_src_mac;
    assign q_key[1] = query_dst_mac;

    attach_match #(.ENTRIES(ENTRIES)) u_learn_match (
        .key     (learn_mac),
        .mac_tab (mac_tab),
        .loc_tab (loc_tab),
        .live    (live),
        .res     (learn_res),
        .idx     (learn_idx)
    );

    attach_table #(.ENTRIES(ENTRIES)) u_table (
        .clk       (clk),
        .rst       (rst),
        .learn_en  (learn_valid),
        .learn_mac (learn_mac),
        .learn_loc ('{dpid: learn_dpid, port: learn_port}),
        .learn_hit (learn_res.hit),
        .learn_idx (learn_idx),
        .mac_tab   (mac_tab),
        .loc_tab   (loc_tab),
        .live      (live),
        .full      (table_full)
    );

    generate
        for (genvar k = 0; k < 2; k++) begin : g_query
            logic [IDX_W-1:0] unused_idx;
            attach_match #(.ENTRIES(ENTRIES)) u_match (
                .key     (q_key[k]),
                .mac_tab (mac_tab),
                .loc_tab (loc_tab),
                .live    (live),
                .res     (q_res[k]),
                .idx     (unused_idx)
            );
            always_ff @(posedge clk) begin
                if (rst) begin
                    held[k] <= '0;
                end else if (query_valid) begin
                    held[k] <= q_res[k];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) res_valid <= 1'b0;
        else     res_valid <= query_valid;
    end

    assign src_hit  = held[0].hit;
    assign src_dpid = held[0].loc.dpid;
    assign src_port = held[0].loc.port;
    assign dst_hit  = held[1].hit;
    assign dst_dpid = held[1].loc.dpid;
    assign dst_port = held[1].loc.port;

    assert_result_follows_query_R4: assert property (@(posedge clk) disable iff (rst)
        query_valid |=> res_valid);

    assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !query_valid |=> (!res_valid && $stable(src_dpid) && $stable(dst_dpid)));

    assert_src_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !src_hit) |-> (src_dpid == '0 && src_port == '0));

    assert_dst_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !dst_hit) |-> (dst_dpid == '0 && dst_port == '0));
endmodule

// File: tb/attach_point_lookup_bench.sv
module attach_point_lookup_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        learn_valid = 1'b0;
    logic [47:0] learn_mac = '0;
    logic [63:0] learn_dpid = '0;
    logic [15:0] learn_port = '0;
    logic        query_valid = 1'b0;
    logic [47:0] query_src_mac = '0;
    logic [47:0] query_dst_mac = '0;
    logic        res_valid, src_hit, dst_hit, table_full;
    logic [63:0] src_dpid, dst_dpid;
    logic [15:0] src_port, dst_port;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    attach_point_lookup #(.ENTRIES(N)) u_attach_point_lookup (
        .clk, .rst, .learn_valid, .learn_mac, .learn_dpid, .learn_port,
        .query_valid, .query_src_mac, .query_dst_mac,
        .res_valid, .src_hit, .src_dpid, .src_port,
        .dst_hit, .dst_dpid, .dst_port, .table_full
    );

    localparam logic [47:0] MA = 48'h02_00_00_00_00_0A;
    localparam logic [47:0] MB = 48'h02_00_00_00_00_0B;
    localparam logic [47:0] MC = 48'h02_00_00_00_00_0C;
    localparam logic [47:0] MD = 48'h02_00_00_00_00_0D;
    localparam logic [47:0] ME = 48'h02_00_00_00_00_0E;
    localparam logic [47:0] MF = 48'h02_00_00_00_00_0F;

    typedef struct packed {
        logic        is_query;
        logic [47:0] m1;
        logic [47:0] m2;
        logic [63:0] dpid;
        logic [15:0] port;
        logic        sh;
        logic [63:0] sd;
        logic [15:0] sp;
        logic        dh;
        logic [63:0] dd;
        logic [15:0] dp;
        logic        full;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, MA, 48'h0, 64'h10, 16'd1, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b0}, // R1 learn A
        '{1'b0, MB, 48'h0, 64'h20, 16'd2, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b0}, // R1 learn B
        '{1'b1, MA, MB, 64'h0, 16'd0, 1'b1, 64'h10, 16'd1, 1'b1, 64'h20, 16'd2, 1'b0}, // R2 both hit
        '{1'b1, MB, MA, 64'h0, 16'd0, 1'b1, 64'h20, 16'd2, 1'b1, 64'h10, 16'd1, 1'b0}, // R2 swapped
        '{1'b1, MA, MC, 64'h0, 16'd0, 1'b1, 64'h10, 16'd1, 1'b0, 64'h0, 16'd0, 1'b0}, // R3 dst miss
        '{1'b0, MA, 48'h0, 64'h30, 16'd7, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b0}, // R5 overwrite A
        '{1'b1, MA, MA, 64'h0, 16'd0, 1'b1, 64'h30, 16'd7, 1'b1, 64'h30, 16'd7, 1'b0}, // R5 R2 same key
        '{1'b0, MC, 48'h0, 64'h40, 16'd3, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b0}, // R6 three used
        '{1'b0, MD, 48'h0, 64'h50, 16'd4, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b1}, // R6 now full
        '{1'b0, ME, 48'h0, 64'h60, 16'd5, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b1}, // R7 dropped
        '{1'b1, ME, MD, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b1, 64'h50, 16'd4, 1'b1}, // R7 R3 E missing
        '{1'b0, MD, 48'h0, 64'h55, 16'd9, 1'b0, 64'h0, 16'd0, 1'b0, 64'h0, 16'd0, 1'b1}, // R7 update when full
        '{1'b1, MD, MC, 64'h0, 16'd0, 1'b1, 64'h55, 16'd9, 1'b1, 64'h40, 16'd3, 1'b1}  // R7 R1 check
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_learn(input logic [47:0] m, input logic [63:0] d, input logic [15:0] p);
        @(negedge clk);
        learn_valid = 1'b1; learn_mac = m; learn_dpid = d; learn_port = p;
        @(negedge clk);
        learn_valid = 1'b0;
    endtask

    task automatic do_query(input logic [47:0] s, input logic [47:0] d);
        @(negedge clk);
        query_valid = 1'b1; query_src_mac = s; query_dst_mac = d;
        @(negedge clk);
        query_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(table_full == 1'b0, "R9 full after reset", 64'(table_full), 64'h0);
        chk(res_valid == 1'b0, "R9 valid after reset", 64'(res_valid), 64'h0);
        chk(src_hit == 1'b0 && dst_hit == 1'b0, "R9 hits after reset", 64'({src_hit, dst_hit}), 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.is_query) begin
                do_query(v.m1, v.m2);
                chk(res_valid == 1'b1, "R4 valid pulse", 64'(res_valid), 64'h1);
                chk(src_hit == v.sh, "R3 src hit", 64'(src_hit), 64'(v.sh));
                chk(src_dpid == v.sd, "R1 R2 src dpid", src_dpid, v.sd);
                chk(src_port == v.sp, "R1 R2 src port", 64'(src_port), 64'(v.sp));
                chk(dst_hit == v.dh, "R3 dst hit", 64'(dst_hit), 64'(v.dh));
                chk(dst_dpid == v.dd, "R1 R2 dst dpid", dst_dpid, v.dd);
                chk(dst_port == v.dp, "R1 R2 dst port", 64'(dst_port), 64'(v.dp));
                @(negedge clk);
                chk(res_valid == 1'b0, "R4 pulse one cycle", 64'(res_valid), 64'h0);
                chk(src_dpid == v.sd && dst_port == v.dp, "R4 result held", src_dpid, v.sd);
            end else begin
                do_learn(v.m1, v.dpid, v.port);
            end
            chk(table_full == v.full, "R6 full flag", 64'(table_full), 64'(v.full));
        end

        // R9 reset clears the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk(table_full == 1'b0, "R9 full cleared", 64'(table_full), 64'h0);
        chk(src_dpid == 64'h0 && src_hit == 1'b0, "R9 result cleared", src_dpid, 64'h0);
        do_query(MA, MD);
        chk(src_hit == 1'b0 && dst_hit == 1'b0, "R9 entries gone", 64'({src_hit, dst_hit}), 64'h0);

        // R8 learn and query in the same cycle
        @(negedge clk);
        learn_valid = 1'b1; learn_mac = MF; learn_dpid = 64'h77; learn_port = 16'd6;
        query_valid = 1'b1; query_src_mac = MF; query_dst_mac = MF;
        @(negedge clk);
        learn_valid = 1'b0; query_valid = 1'b0;
        chk(src_hit == 1'b0 && dst_hit == 1'b0, "R8 query sees pre-learn table", 64'({src_hit, dst_hit}), 64'h0);
        do_query(MF, MF);
        chk(src_hit && src_dpid == 64'h77 && dst_port == 16'd6, "R8 entry visible next query", src_dpid, 64'h77);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule